// File: doc/BRIEF.md
# Modem Status and Loopback Register

This block holds the two modem handshake registers of a serial controller. A control register drives four modem output lines: request-to-send, data-terminal-ready and two general-purpose outputs. A status register tracks four modem input lines: clear-to-send, data-set-ready, carrier-detect and ring. Each input is resynchronised before it is used. The current input levels sit in the upper half of the status byte. Sticky change flags sit in the lower half. The OR of the change flags goes to the interrupt logic on a separate output.

Software reads and writes both registers through a byte-wide port with a one-bit register select. Reading the status register returns its contents and then clears the change flags. A loopback mode exists for self-test. In loopback the external outputs are held inactive and a status read reflects the control outputs instead of the pins. Every level is active-high: a 1 means the line is asserted.

Top module: `mdm_regs_top`

## Requirements
- R1: After reset the status register reads 0xB0, the control register reads 0x08, out2Out is 1, rtsOut, dtrOut and out1Out are 0, and deltaPend is 0.
- R2: A write with regSel=0 stores wrData[4:0] in the control register, whose bits are loopback (4), out2 (3), out1 (2), rts (1) and dtr (0). A read with regSel=0 returns those bits with bits 7:5 at zero. Outside loopback, each output pin equals its control bit.
- R3: Each modem input passes through a two-flop synchroniser. The status upper nibble carries carrier-detect (bit 7), ring (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). A pin change shows in the status register on the third rising edge after the change.
- R4: When carrier-detect, data-set-ready or clear-to-send changes level in either direction, its change flag is set and stays set until a status read. The flags are bit 3, bit 1 and bit 0 respectively.
- R5: The ring change flag (bit 2) is set only when ring goes from 1 to 0. A rising ring leaves it unchanged.
- R6: A status read outside loopback (rdEn=1, regSel=1) returns the full byte and clears bits 3:0 at the following edge, keeping bits 7:4. A change flag raised on that same edge is kept.
- R7: In loopback, a status read returns out2 as bit 7, out1 as bit 6, dtr as bit 5 and rts as bit 4, with bits 3:0 at zero. Such a read does not clear the stored change flags.
- R8: While loopback is set, rtsOut, dtrOut, out1Out and out2Out are all 0.
- R9: deltaPend is 1 exactly when any stored change flag (status bits 3:0) is set, including while loopback is active.
- R10: A write with regSel=1 has no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regSel | input | 1 | 0 selects control, 1 selects status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdEn is high, else 0 |
| ctsIn | input | 1 | Clear-to-send pin, asynchronous |
| dsrIn | input | 1 | Data-set-ready pin, asynchronous |
| dcdIn | input | 1 | Carrier-detect pin, asynchronous |
| riIn | input | 1 | Ring pin, asynchronous |
| rtsOut | output | 1 | Request-to-send output |
| dtrOut | output | 1 | Data-terminal-ready output |
| out1Out | output | 1 | General-purpose output 1 |
| out2Out | output | 1 | General-purpose output 2 |
| deltaPend | output | 1 | Any change flag set |

## Verification
A corrupted synchroniser or level register shows at the ports three edges after a pin change. It appears as a wrong upper nibble on the next status read and as a spurious or missing change flag on deltaPend. A faulty clear or edge-detect term first appears on the read after the one that should have cleared the flags. Wrong ring-edge polarity appears there too, or as deltaPend rising after a rising ring. Loopback mapping errors and output gating errors show on the same cycle the control register is written or read.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  // Positions inside a nibble of modem levels / change flags
  localparam int unsigned NIB_DCD = 3;
  localparam int unsigned NIB_RI  = 2;
  localparam int unsigned NIB_DSR = 1;
  localparam int unsigned NIB_CTS = 0;

  // Control register bit positions
  localparam int unsigned CB_LOOP = 4;
  localparam int unsigned CB_OUT2 = 3;
  localparam int unsigned CB_OUT1 = 2;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_DTR  = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic ctlWr;    // load control register
    logic statClr;  // clear change flags at this edge
    logic rdStat;   // status selected for read
    logic rdCtl;    // control selected for read
  } mdmStrobe_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= RST_VAL;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= RST_VAL;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       regSel,
  input  logic       loopOn,
  output mdmStrobe_t strb
);
  always_comb begin
    strb         = '0;
    strb.ctlWr   = wrEn & ~regSel;
    strb.rdStat  = rdEn & regSel;
    strb.rdCtl   = rdEn & ~regSel;
    // Loopback reads show the control mirror and leave stored flags alone
    strb.statClr = rdEn & regSel & ~loopOn;
  end
endmodule

// File: rtl/mdm_dpath.sv
module mdm_dpath
  import mdm_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CTL_W       = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] STAT_RST = 8'hB0,
  parameter logic [CTL_W-1:0]  CTL_RST  = 5'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdmStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        pinNib,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        outNib,
  output logic              loopOn,
  output logic              deltaPend,
  output logic [DATA_W-1:0] statQ,
  output logic [CTL_W-1:0]  ctlQ,
  output logic [3:0]        syncNib
);
  localparam int unsigned NIB = DATA_W / 2;

  logic [NIB-1:0]    lvlOld;
  logic [NIB-1:0]    edgeAny;
  logic [NIB-1:0]    newFlag;
  logic [NIB-1:0]    keptFlag;
  logic [DATA_W-1:0] loopView;

  mdm_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STAT_RST[DATA_W-1:NIB])
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinNib),
    .syncOut(syncNib)
  );

  assign lvlOld  = statQ[DATA_W-1:NIB];
  assign edgeAny = syncNib ^ lvlOld;

  always_comb begin
    newFlag          = edgeAny;
    // Ring flag only on a trailing (1 -> 0) edge
    newFlag[NIB_RI]  = lvlOld[NIB_RI] & ~syncNib[NIB_RI];
    keptFlag         = strb.statClr ? '0 : statQ[NIB-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= STAT_RST;
    else       statQ <= {syncNib, keptFlag | newFlag};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctlQ <= CTL_RST;
    else if (strb.ctlWr) ctlQ <= wrData[CTL_W-1:0];
  end

  assign loopOn = ctlQ[CB_LOOP];

  always_comb begin
    loopView = '0;
    loopView[NIB + NIB_DCD] = ctlQ[CB_OUT2];
    loopView[NIB + NIB_RI]  = ctlQ[CB_OUT1];
    loopView[NIB + NIB_DSR] = ctlQ[CB_DTR];
    loopView[NIB + NIB_CTS] = ctlQ[CB_RTS];
  end

  always_comb begin
    rdData = '0;
    if (strb.rdStat)     rdData = loopOn ? loopView : statQ;
    else if (strb.rdCtl) rdData = {{(DATA_W-CTL_W){1'b0}}, ctlQ};
  end

  // {out2, out1, rts, dtr}, forced inactive in loopback
  assign outNib    = loopOn ? 4'b0000 : ctlQ[CB_OUT2:CB_DTR];
  assign deltaPend = |statQ[NIB-1:0];
endmodule

// File: rtl/mdm_regs_top.sv
module mdm_regs_top
  import mdm_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CTL_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              riIn,
  output logic              rtsOut,
  output logic              dtrOut,
  output logic              out1Out,
  output logic              out2Out,
  output logic              deltaPend
);
  mdmStrobe_t        strb;
  logic              loopOn;
  logic [3:0]        outNib;
  logic [DATA_W-1:0] statRegW;
  logic [CTL_W-1:0]  ctlRegW;
  logic [3:0]        syncNibW;

  mdm_ctrl u_ctrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .regSel(regSel),
    .loopOn(loopOn),
    .strb  (strb)
  );

  mdm_dpath #(
    .DATA_W     (DATA_W),
    .CTL_W      (CTL_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .pinNib   ({dcdIn, riIn, dsrIn, ctsIn}),
    .rdData   (rdData),
    .outNib   (outNib),
    .loopOn   (loopOn),
    .deltaPend(deltaPend),
    .statQ    (statRegW),
    .ctlQ     (ctlRegW),
    .syncNib  (syncNibW)
  );

  assign {out2Out, out1Out, rtsOut, dtrOut} = outNib;
endmodule

// File: rtl/mdm_regs_chk.sv
module mdm_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdEn,
  input logic       regSel,
  input logic [7:0] rdData,
  input logic       deltaPend,
  input logic       rtsOut,
  input logic       dtrOut,
  input logic       out1Out,
  input logic       out2Out,
  input logic [4:0] ctlReg,
  input logic [7:0] statReg,
  input logic [3:0] syncNib
);
  p_ctl_upper_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !regSel) |-> (rdData[7:5] == 3'b000));

  p_ri_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statReg[6]) && !$past(statReg[2])) |-> !statReg[2]);

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel && !ctlReg[4] && (syncNib == statReg[7:4]))
      |=> (statReg[3:0] == 4'b0000));

  p_loop_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel && ctlReg[4]) |-> (rdData[3:0] == 4'b0000));

  p_loop_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[4] |-> !(rtsOut || dtrOut || out1Out || out2Out));

  p_pend_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel && !ctlReg[4]) |-> (deltaPend == (|rdData[3:0])));
endmodule

bind mdm_regs_top mdm_regs_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdEn     (rdEn),
  .regSel   (regSel),
  .rdData   (rdData),
  .deltaPend(deltaPend),
  .rtsOut   (rtsOut),
  .dtrOut   (dtrOut),
  .out1Out  (out1Out),
  .out2Out  (out2Out),
  .ctlReg   (ctlRegW),
  .statReg  (statRegW),
  .syncNib  (syncNibW)
);

// File: tb/mdm_regs_top_tb_top.sv
module mdm_regs_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, regSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       ctsIn = 1'b1, dsrIn = 1'b1, dcdIn = 1'b1, riIn = 1'b0;
  logic       rtsOut, dtrOut, out1Out, out2Out, deltaPend;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  mdm_regs_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn), .riIn(riIn),
    .rtsOut(rtsOut), .dtrOut(dtrOut), .out1Out(out1Out), .out2Out(out2Out),
    .deltaPend(deltaPend)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2;

  typedef struct packed {
    logic [1:0] op;
    logic       sel;
    logic [7:0] data;    // write data, or pins {dcd,ri,dsr,cts} in [3:0]
    logic [7:0] expRd;
    logic [3:0] expOut;  // {out2,out1,rts,dtr}
    logic       expPend;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  1'b1, 8'h00, 8'hB0, 4'h8, 1'b0, 4'd1},  // R1 status reset
    '{OP_RD,  1'b0, 8'h00, 8'h08, 4'h8, 1'b0, 4'd1},  // R1 control reset
    '{OP_WR,  1'b0, 8'hE3, 8'h00, 4'h0, 1'b0, 4'd2},
    '{OP_RD,  1'b0, 8'h00, 8'h03, 4'h3, 1'b0, 4'd2},  // R2 bits 7:5 dropped
    '{OP_PIN, 1'b0, 8'h0A, 8'h00, 4'h0, 1'b0, 4'd4},
    '{OP_RD,  1'b1, 8'h00, 8'hA1, 4'h3, 1'b1, 4'd4},  // R4 cts falls
    '{OP_RD,  1'b1, 8'h00, 8'hA0, 4'h3, 1'b0, 4'd6},  // R6 cleared
    '{OP_PIN, 1'b0, 8'h0E, 8'h00, 4'h0, 1'b0, 4'd5},
    '{OP_RD,  1'b1, 8'h00, 8'hE0, 4'h3, 1'b0, 4'd5},  // R5 ring rise no flag
    '{OP_PIN, 1'b0, 8'h0A, 8'h00, 4'h0, 1'b0, 4'd5},
    '{OP_RD,  1'b1, 8'h00, 8'hA4, 4'h3, 1'b1, 4'd5},  // R5 ring fall flags
    '{OP_RD,  1'b1, 8'h00, 8'hA0, 4'h3, 1'b0, 4'd6},  // R6
    '{OP_PIN, 1'b0, 8'h00, 8'h00, 4'h0, 1'b0, 4'd4},
    '{OP_RD,  1'b1, 8'h00, 8'h0A, 4'h3, 1'b1, 4'd4},  // R4 falling edges
    '{OP_RD,  1'b1, 8'h00, 8'h00, 4'h3, 1'b0, 4'd3},  // R3 levels low
    '{OP_WR,  1'b1, 8'hFF, 8'h00, 4'h0, 1'b0, 4'd10},
    '{OP_RD,  1'b1, 8'h00, 8'h00, 4'h3, 1'b0, 4'd10}, // R10 write ignored
    '{OP_PIN, 1'b0, 8'h0F, 8'h00, 4'h0, 1'b0, 4'd4},
    '{OP_WR,  1'b0, 8'h15, 8'h00, 4'h0, 1'b0, 4'd7},
    '{OP_RD,  1'b1, 8'h00, 8'h60, 4'h0, 1'b1, 4'd7},  // R7 out1,dtr mirrored
    '{OP_RD,  1'b0, 8'h00, 8'h15, 4'h0, 1'b1, 4'd8},  // R8 outputs quiet
    '{OP_WR,  1'b0, 8'h1A, 8'h00, 4'h0, 1'b0, 4'd7},
    '{OP_RD,  1'b1, 8'h00, 8'h90, 4'h0, 1'b1, 4'd7},  // R7 out2,rts mirrored
    '{OP_WR,  1'b0, 8'h0A, 8'h00, 4'h0, 1'b0, 4'd9}
  };

  task automatic check(input logic [7:0] expRd, input logic [3:0] expOut,
                       input logic expPend, input string tag);
    logic [3:0] act;
    act = {out2Out, out1Out, rtsOut, dtrOut};
    nChecks++;
    if (rdData !== expRd || act !== expOut || deltaPend !== expPend) begin
      nFails++;
      $display("FAIL %s: rd=%02h out=%h pend=%b expected rd=%02h out=%h pend=%b",
               tag, rdData, act, deltaPend, expRd, expOut, expPend);
    end
  endtask

  task automatic doWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic sel, input logic [7:0] expRd,
                        input logic [3:0] expOut, input logic expPend,
                        input string tag);
    @(negedge clk);
    rdEn = 1'b1; regSel = sel;
    #2;
    check(expRd, expOut, expPend, tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setPins(input logic [3:0] p);
    @(negedge clk);
    {dcdIn, riIn, dsrIn, ctsIn} = p;
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:  doWrite(VECS[i].sel, VECS[i].data);
        OP_PIN: setPins(VECS[i].data[3:0]);
        default: doRead(VECS[i].sel, VECS[i].expRd, VECS[i].expOut,
                        VECS[i].expPend, $sformatf("R%0d vec%0d", VECS[i].req, i));
      endcase
    end

    // R7: loopback reads left stored flags intact (dcd, dsr, cts rose)
    doRead(1'b1, 8'hFB, 4'hA, 1'b1, "R7 flags kept after loopback");
    doRead(1'b1, 8'hF0, 4'hA, 1'b0, "R9 pend clears with flags");

    // R6: flag raised on the clearing edge survives
    @(negedge clk);
    dcdIn = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b1; regSel = 1'b1;
    #2;
    check(8'hF0, 4'hA, 1'b0, "R6 read before coincident edge");
    @(negedge clk);
    rdEn = 1'b0;
    doRead(1'b1, 8'h78, 4'hA, 1'b1, "R6 coincident flag kept");

    // R3: level appears exactly on third edge
    @(negedge clk);
    ctsIn = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b1; regSel = 1'b1;
    #2;
    check(8'h70, 4'hA, 1'b0, "R3 not yet visible after two edges");
    @(negedge clk);
    rdEn = 1'b0;
    doRead(1'b1, 8'h61, 4'hA, 1'b1, "R3 visible after third edge");

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rstN = 1'b0;
    {dcdIn, riIn, dsrIn, ctsIn} = 4'b1011;
    @(negedge clk);
    rstN = 1'b1;
    doRead(1'b0, 8'h08, 4'h8, 1'b0, "R1 control after second reset");
    doRead(1'b1, 8'hB0, 4'h8, 1'b0, "R1 status after second reset");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule